// File: doc/BRIEF.md
# Flash status and write-protection guard

This block keeps the 8-bit status byte of a serial flash device and decides whether each write-type request may run. Its inputs are requests that have already been decoded: set the write-enable latch, clear it, page program, sector erase, bulk erase and status write. The serial shifter and the memory array are outside the block.

A program, erase or status write is allowed only when three conditions hold. The enable latch must be set. The target must lie outside the protected region that the block-protect field selects. For a status write, the status-lock bit and the write-protect pin together must not forbid it. When a request is allowed, the block pulses `op_go` to the array side and raises the busy bit for a length of time fixed by a parameter for that kind of operation. A refused request does nothing except drop the enable latch.

Top module: `flash_status_guard`

## Requirements
- R1: After reset `status` reads 8'h00 and `op_go` is 0.
- R2: The status layout is: bit 7 status-lock, bits 6..5 always 0, bits 4..2 protect field, bit 1 enable latch, bit 0 busy. While not busy, request code 1 sets the enable latch and request code 2 clears it.
- R3: The write-type codes are 3 (page program), 4 (sector erase), 5 (bulk erase) and 6 (status write). Any of them is refused while the enable latch is 0: `op_go` stays 0 and busy stays 0.
- R4: An accepted write-type request sets `op_go` for one cycle after the request cycle. From that same cycle, busy reads 1 for exactly PROG_CYC, SECT_CYC, BULK_CYC or STAT_CYC cycles, according to the kind. When busy ends, the enable latch and busy both read 0.
- R5: A refused write-type request clears the enable latch.
- R6: The sector is `cmd_addr[ADDR_W-1 -: SECT_W]`. A protect field value p that is nonzero protects the top 2^(p-1) sectors, and the value 7 protects all 64. A page program or sector erase aimed at a protected sector is refused. One aimed at an unprotected sector is accepted.
- R7: A bulk erase is refused unless the protect field is 0.
- R8: An accepted status write takes the status-lock bit from `cmd_wdata[7]` and the protect field from `cmd_wdata[4:2]`. The new values appear only when busy ends. All other data bits are ignored.
- R9: A status write is refused when status-lock is 1 and `wp_n` is 0. With `wp_n` at 1 it is accepted.
- R10: While busy, every request is ignored, including codes 1 and 2: `op_go` stays 0 and the enable latch keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A decoded request is present this cycle |
| cmd_op | input | 3 | Request code |
| cmd_addr | input | ADDR_W | Target byte address of a program or erase |
| cmd_wdata | input | 8 | New status byte for a status write |
| wp_n | input | 1 | Write-protect pin, active low |
| status | output | 8 | Status byte |
| op_go | output | 1 | One-cycle start pulse for an accepted operation |

## Verification
Most internal faults show at the ports within a cycle or two of the request that exposes them. A wrong latch or protect value shows as an `op_go` pulse that is missing or that should not be there, one cycle after the request. A wrong busy counter shows as a busy window longer or shorter than the parameter, measured edge by edge. A pending status value applied at the wrong moment shows as a protect field that changes while busy is still 1. A fault in the ignore-while-busy rule shows as a latch change during the busy window, or as a second busy period after it.

// File: rtl/flash_status_guard.sv
module flash_status_guard #(
  parameter int ADDR_W   = 24,
  parameter int SECT_W   = 6,
  parameter int PROG_CYC = 12,
  parameter int SECT_CYC = 30,
  parameter int BULK_CYC = 50,
  parameter int STAT_CYC = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_wdata,
  input  logic              wp_n,
  output logic [7:0]        status,
  output logic              op_go
);
  localparam logic [2:0] OP_SETL = 3'd1, OP_CLRL = 3'd2, OP_PROG = 3'd3,
                         OP_SECT = 3'd4, OP_BULK = 3'd5, OP_STAT = 3'd6;
  localparam int MAX_AB = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int MAX_CD = (BULK_CYC > STAT_CYC) ? BULK_CYC : STAT_CYC;
  localparam int MAXC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W  = $clog2(MAXC + 1);
  localparam int SPAN_W = SECT_W + 8;
  localparam int NSECT  = 1 << SECT_W;

  logic             wip_q, wel_q, lock_q, pend_stat, lock_nx;
  logic [2:0]       bp_q, bp_nx;
  logic [CNT_W-1:0] cnt_q, dur;
  logic             allow, is_wr;

  wire [SECT_W-1:0] sect = cmd_addr[ADDR_W-1 -: SECT_W];
  wire [SPAN_W-1:0] span = (bp_q == 3'd0) ? '0 : (SPAN_W'(1) << (bp_q - 3'd1));
  wire in_prot  = ({8'b0, sect} + span) >= SPAN_W'(NSECT);
  wire hw_lock  = lock_q && !wp_n;
  wire idle_req = cmd_valid && !wip_q;
  wire accept   = idle_req && is_wr && wel_q && allow;
  wire reject   = idle_req && is_wr && !(wel_q && allow);

  logic unused_bits;
  assign unused_bits = ^{cmd_wdata[6:5], cmd_wdata[1:0], cmd_addr[ADDR_W-SECT_W-1:0]};

  assign status = {lock_q, 2'b00, bp_q, wel_q, wip_q};

  always_comb begin
    is_wr = 1'b1;
    allow = 1'b0;
    dur   = '0;
    case (cmd_op)
      OP_PROG: begin allow = !in_prot;       dur = CNT_W'(PROG_CYC - 1); end
      OP_SECT: begin allow = !in_prot;       dur = CNT_W'(SECT_CYC - 1); end
      OP_BULK: begin allow = (bp_q == 3'd0); dur = CNT_W'(BULK_CYC - 1); end
      OP_STAT: begin allow = !hw_lock;       dur = CNT_W'(STAT_CYC - 1); end
      default: is_wr = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wip_q <= 1'b0; wel_q <= 1'b0; lock_q <= 1'b0; bp_q <= 3'd0;
      pend_stat <= 1'b0; lock_nx <= 1'b0; bp_nx <= 3'd0;
      cnt_q <= '0; op_go <= 1'b0;
    end else begin
      op_go <= accept;
      if (wip_q) begin
        if (cnt_q == '0) begin
          wip_q <= 1'b0;
          wel_q <= 1'b0;
          if (pend_stat) begin
            lock_q <= lock_nx;
            bp_q   <= bp_nx;
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (accept) begin
        wip_q     <= 1'b1;
        cnt_q     <= dur;
        pend_stat <= (cmd_op == OP_STAT);
        lock_nx   <= cmd_wdata[7];
        bp_nx     <= cmd_wdata[4:2];
      end else if (reject) begin
        wel_q <= 1'b0;
      end else if (idle_req && cmd_op == OP_SETL) begin
        wel_q <= 1'b1;
      end else if (idle_req && cmd_op == OP_CLRL) begin
        wel_q <= 1'b0;
      end
    end
  end

  p_go_needs_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op_go |-> $past(wel_q) && !$past(wip_q));

  p_end_drops_wel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip_q) |-> !wel_q);

  p_bulk_unprot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_go && $past(cmd_op) == OP_BULK) |-> $past(bp_q) == 3'd0);

  p_hw_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_go && $past(cmd_op) == OP_STAT) |-> !($past(lock_q) && !$past(wp_n)));

  p_busy_ignores_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wip_q) |-> !op_go);

  p_protect_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wip_q) && wip_q) |-> $stable(bp_q) && $stable(lock_q));
endmodule

// File: tb/sim_flash_status_guard.sv
module sim_flash_status_guard;
  localparam int TP = 12, TS = 30, TB = 50, TW = 6;
  logic clk = 0, rst_n = 0, cmd_valid = 0, wp_n = 1;
  logic [2:0] cmd_op = 0;
  logic [23:0] cmd_addr = 0;
  logic [7:0] cmd_wdata = 0;
  logic [7:0] status;
  logic op_go;
  int total = 0, bad = 0;

  flash_status_guard #(.PROG_CYC(TP), .SECT_CYC(TS), .BULK_CYC(TB), .STAT_CYC(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .wp_n(wp_n),
    .status(status), .op_go(op_go));

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [23:0] a, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 0; cmd_op = 0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (status[0] && n < 10000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic run_ok(input string tag, input logic [2:0] op, input logic [23:0] a,
                        input logic [7:0] d, input int len);
    int n;
    issue(3'd1, 0, 0);
    issue(op, a, d);
    chk({tag, " go"}, op_go, 1);
    busy_len(n);
    chk({tag, " busy length"}, n, len);
  endtask

  task automatic run_refused(input string tag, input logic [2:0] op, input logic [23:0] a,
                             input logic [7:0] d, input logic [7:0] exp_st);
    issue(3'd1, 0, 0);
    issue(op, a, d);
    chk({tag, " no go"}, op_go, 0);
    chk({tag, " status"}, status, exp_st);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 status", status, 8'h00);
    chk("R1 go", op_go, 0);
  endtask

  task automatic t_latch;
    issue(3'd1, 0, 0); chk("R2 set latch", status, 8'h02);
    issue(3'd2, 0, 0); chk("R2 clear latch", status, 8'h00);
  endtask

  task automatic t_no_latch;
    issue(3'd3, 0, 0);
    chk("R3 no go", op_go, 0);
    chk("R3 status", status, 8'h00);
  endtask

  task automatic t_timing;
    run_ok("R4 program", 3'd3, 24'h000100, 0, TP);
    chk("R4 after program", status, 8'h00);
    run_ok("R4 sector", 3'd4, 24'h040000, 0, TS);
    chk("R4 after sector", status, 8'h00);
  endtask

  task automatic t_stat_write;
    int n;
    issue(3'd1, 0, 0);
    issue(3'd6, 0, 8'h6B);
    chk("R8 field held while busy", status, 8'h03);
    busy_len(n);
    chk("R4 status busy length", n, TW);
    chk("R8 applied", status, 8'h08);
  endtask

  task automatic t_protect;
    run_refused("R6 sector 62 program", 3'd3, 24'hF80000, 0, 8'h08);
    chk("R5 latch dropped", status[1], 0);
    run_refused("R6 sector 63 erase", 3'd4, 24'hFC0010, 0, 8'h08);
    run_ok("R6 sector 61 program", 3'd3, 24'hF7FFFF, 0, TP);
    run_refused("R7 bulk refused", 3'd5, 0, 0, 8'h08);
    run_ok("R8 clear field", 3'd6, 0, 8'h00, TW);
    chk("R8 cleared", status, 8'h00);
    run_ok("R7 bulk accepted", 3'd5, 0, 0, TB);
    run_ok("R8 field 7", 3'd6, 0, 8'h1C, TW);
    chk("R8 field 7 status", status, 8'h1C);
    run_refused("R6 all protected", 3'd3, 24'h000000, 0, 8'h1C);
  endtask

  task automatic t_hw_lock;
    run_ok("R9 set lock", 3'd6, 0, 8'h84, TW);
    chk("R9 lock status", status, 8'h84);
    run_refused("R6 top sector", 3'd3, 24'hFC0000, 0, 8'h84);
    run_ok("R6 next sector", 3'd3, 24'hF80000, 0, TP);
    wp_n = 0;
    run_refused("R9 pin low", 3'd6, 0, 8'h00, 8'h84);
    wp_n = 1;
    run_ok("R9 pin high", 3'd6, 0, 8'h00, TW);
    chk("R9 unlocked", status, 8'h00);
  endtask

  task automatic t_busy;
    int n;
    issue(3'd1, 0, 0);
    issue(3'd4, 0, 0);
    issue(3'd2, 0, 0);
    chk("R10 clear ignored", status, 8'h03);
    issue(3'd3, 24'h000200, 0);
    chk("R10 program ignored", op_go, 0);
    busy_len(n);
    @(negedge clk);
    chk("R10 no second run", status, 8'h00);
    chk("R10 no late go", op_go, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_latch();
    t_no_latch();
    t_timing();
    t_stat_write();
    t_protect();
    t_hw_lock();
    t_busy();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule